// File: doc/BRIEF.md
# Flash ECC Wrapper with Write-Once Check Storage

This block sits between a 32-bit processor flash port and a flash array. Each aligned 32-bit word is stored with a 6-bit Hamming check code. The code is computed when the word is written and stored together with it. On a read, the wrapper evaluates the 32 raw data bits and the 6 stored check bits together. It repairs any single flipped bit before the word is returned. It also flags syndromes that point outside the codeword.

The check storage can be programmed only once after an erase. For this reason the wrapper keeps a written flag for every word. A write is rejected when it is misaligned, when it covers only part of a word, or when the target word has already been written. A sector erase clears the data, the check bits and the written flags of one sector. The array itself sits outside the block, behind a simple port. The array write and the array erase take effect at the same clock edge as the request. Array read data is combinational from the array address.

Top module: `flash_ecc_wrap`

## Requirements
- R1: An accepted write drives `arr_wdata_o = {check[5:0], data[31:0]}`. Codeword positions run from 1 to 38. Check bit k sits at position 2^k. Data bit i sits at the i-th position, counting upward, that is not a power of two. Check bit k is the XOR of all data bits whose position has bit k set.
- R2: A read whose stored word differs from a valid codeword in exactly one data bit returns the original data, with `corr_o`=1 and `uncorr_o`=0.
- R3: A read whose stored word differs from a valid codeword in exactly one check bit returns the data unchanged, with `corr_o`=1 and `uncorr_o`=0.
- R4: The syndrome is the XOR of the positions of all set codeword bits. When it is above 38, the read returns the raw stored data with `uncorr_o`=1 and `corr_o`=0.
- R5: A word whose 38 stored bits are all ones counts as erased. Reading it returns 0xFFFFFFFF with both flags low.
- R6: A read returns `rvalid_o`, `rdata_o` and its flags exactly one cycle after the request. The flags last for that one cycle only.
- R7: A write with `addr_i[1:0]` not equal to 0, or with `be_i` not equal to 4'hF, is rejected. `wr_rej_o` pulses one cycle later, no array write is issued, and the stored word is left unchanged.
- R8: A write to a word already written since its last erase is rejected. `wr_rej_o` pulses one cycle later and the stored word keeps its earlier value.
- R9: An erase request drives `arr_erase_o` with `arr_sector_o = addr_i[10]`, the 1 KB sector index. It clears the written flags of that sector only, so words in the other sector stay write-protected.
- R10: One operation runs per cycle, with priority erase over write over read. A read that loses to a write or an erase produces no `rvalid_o`, and a write that loses to an erase is not issued.
- R11: While `rst_ni` is low, `rvalid_o`, `corr_o`, `uncorr_o`, `wr_rej_o` and `arr_we_o` are low, and all written flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| erase_i | input | 1 | Sector erase request, sector taken from `addr_i` |
| addr_i | input | 11 | Byte address |
| be_i | input | 4 | Byte enables of the write |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| rdata_o | output | 32 | Corrected read data |
| corr_o | output | 1 | Single-bit error was corrected |
| uncorr_o | output | 1 | Syndrome points outside the codeword |
| wr_rej_o | output | 1 | Write was rejected |
| arr_addr_o | output | 9 | Array word address |
| arr_we_o | output | 1 | Array write strobe |
| arr_wdata_o | output | 38 | Array write word, check bits above data |
| arr_erase_o | output | 1 | Array sector erase strobe |
| arr_sector_o | output | 1 | Sector to erase |
| arr_rdata_i | input | 38 | Raw array word at `arr_addr_o` |

## Verification
The decoder is exercised with five read patterns:
- clean codewords with random data;
- one flipped data bit, which tests the position mapping of data bits;
- one flipped check bit, which must set the flag but leave the data unchanged;
- a flipped top check bit paired with a data bit whose position XOR exceeds 38, which separates the uncorrectable path from a wrong correction;
- all-ones erased words, including a written 0xFFFFFFFF, which separates an erased word from valid all-ones data.

Writes are tried at random word addresses and repeated to already-written words. Write shapes with misaligned addresses and partial byte enables are also tried. A sector erase is followed by rewrites on both sides of the sector boundary. This separates clearing per word from clearing per sector. Finally, colliding requests confirm the priority order.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  localparam int DW = 32;
  localparam int CW = 6;
  localparam int NW = DW + CW;

  // codeword position (1-based) of data bit idx
  function automatic logic [CW-1:0] data_pos(input int unsigned idx);
    int unsigned n;
    logic [CW-1:0] r;
    n = 0;
    r = '0;
    for (int unsigned p = 1; p <= NW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = CW'(p);
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fecc_enc.sv
module fecc_enc
  import fecc_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  always_comb begin
    logic [CW-1:0] pos;
    chk_o = '0;
    for (int i = 0; i < DW; i++) begin
      pos = data_pos(i);
      for (int k = 0; k < CW; k++) begin
        if (pos[k]) chk_o[k] = chk_o[k] ^ data_i[i];
      end
    end
  end
endmodule

// File: rtl/fecc_dec.sv
module fecc_dec
  import fecc_pkg::*;
(
  input  logic [NW-1:0] raw_i,
  output logic [DW-1:0] data_o,
  output logic          corr_o,
  output logic          uncorr_o
);
  logic [NW:0]   cw;
  logic [CW-1:0] syn;
  logic          erased;

  always_comb begin
    cw = '0;
    for (int i = 0; i < DW; i++) cw[data_pos(i)] = raw_i[i];
    for (int k = 0; k < CW; k++) cw[CW'(1 << k)] = raw_i[DW+k];

    syn = '0;
    for (int p = 1; p <= NW; p++) begin
      if (cw[p]) syn = syn ^ CW'(p);
    end

    erased   = &raw_i;
    corr_o   = 1'b0;
    uncorr_o = 1'b0;
    if (!erased && syn != '0) begin
      if (int'(syn) <= NW) begin
        cw[syn] = ~cw[syn];
        corr_o  = 1'b1;
      end else begin
        uncorr_o = 1'b1;
      end
    end

    for (int i = 0; i < DW; i++) data_o[i] = cw[data_pos(i)];
  end
endmodule

// File: rtl/fecc_wr_guard.sv
module fecc_wr_guard #(
  parameter int WORDS   = 512,
  parameter int WPS     = 256,
  parameter int WADDR_W = 9,
  parameter int SEC_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               erase_i,
  input  logic               shape_ok_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [SEC_W-1:0]   sector_i,
  output logic               accept_o,
  output logic               reject_o
);
  logic [WORDS-1:0] written_q;
  logic             wr_act;

  assign wr_act   = wr_i & ~erase_i;
  assign accept_o = wr_act & shape_ok_i & ~written_q[waddr_i];
  assign reject_o = wr_act & ~accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= '0;
    end else if (erase_i) begin
      for (int w = 0; w < WORDS; w++) begin
        if (SEC_W'(w / WPS) == sector_i) written_q[w] <= 1'b0;
      end
    end else if (accept_o) begin
      written_q[waddr_i] <= 1'b1;
    end
  end

  // R9: erase never coincides with an accepted write
  p_erase_blocks_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |-> !accept_o);
endmodule

// File: rtl/flash_ecc_wrap.sv
module flash_ecc_wrap
  import fecc_pkg::*;
#(
  parameter  int SECTORS      = 2,
  parameter  int SECTOR_BYTES = 1024,
  localparam int WPS          = SECTOR_BYTES / 4,
  localparam int WORDS        = SECTORS * WPS,
  localparam int ADDR_W       = $clog2(SECTORS * SECTOR_BYTES),
  localparam int WADDR_W      = ADDR_W - 2,
  localparam int SEC_LSB      = $clog2(SECTOR_BYTES),
  localparam int SEC_W        = ADDR_W - SEC_LSB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               erase_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [3:0]         be_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               rvalid_o,
  output logic [DW-1:0]      rdata_o,
  output logic               corr_o,
  output logic               uncorr_o,
  output logic               wr_rej_o,
  output logic [WADDR_W-1:0] arr_addr_o,
  output logic               arr_we_o,
  output logic [NW-1:0]      arr_wdata_o,
  output logic               arr_erase_o,
  output logic [SEC_W-1:0]   arr_sector_o,
  input  logic [NW-1:0]      arr_rdata_i
);
  logic [CW-1:0] chk;
  logic [DW-1:0] dec_data;
  logic          dec_corr, dec_uncorr;
  logic          shape_ok, accept, reject, rd_act;

  assign shape_ok     = (addr_i[1:0] == 2'b00) && (be_i == 4'hF);
  assign rd_act       = rd_i & ~wr_i & ~erase_i;
  assign arr_addr_o   = addr_i[ADDR_W-1:2];
  assign arr_sector_o = addr_i[ADDR_W-1:SEC_LSB];
  assign arr_erase_o  = erase_i;
  assign arr_we_o     = accept;
  assign arr_wdata_o  = {chk, wdata_i};

  fecc_enc u_enc (.data_i(wdata_i), .chk_o(chk));

  fecc_dec u_dec (
    .raw_i   (arr_rdata_i),
    .data_o  (dec_data),
    .corr_o  (dec_corr),
    .uncorr_o(dec_uncorr)
  );

  fecc_wr_guard #(
    .WORDS  (WORDS),
    .WPS    (WPS),
    .WADDR_W(WADDR_W),
    .SEC_W  (SEC_W)
  ) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .erase_i   (erase_i),
    .shape_ok_i(shape_ok),
    .waddr_i   (arr_addr_o),
    .sector_i  (arr_sector_o),
    .accept_o  (accept),
    .reject_o  (reject)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      corr_o   <= 1'b0;
      uncorr_o <= 1'b0;
      wr_rej_o <= 1'b0;
    end else begin
      rvalid_o <= rd_act;
      corr_o   <= rd_act & dec_corr;
      uncorr_o <= rd_act & dec_uncorr;
      wr_rej_o <= reject;
      if (rd_act) rdata_o <= dec_data;
    end
  end

  p_rd_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !erase_i) |=> rvalid_o);

  p_flag_in_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o || uncorr_o) |-> rvalid_o);

  p_bad_shape_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i[1:0] != 2'b00 || be_i != 4'hF)) |-> !arr_we_o);

  p_rej_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rej_o |-> $past(wr_i && !erase_i));

  p_no_rewrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && $past(arr_we_o) && arr_addr_o == $past(arr_addr_o)) |-> !arr_we_o);

  p_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i || wr_i) |=> !rvalid_o);
endmodule

// File: tb/flash_ecc_wrap_bench.sv
module flash_ecc_wrap_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0, erase_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o, corr_o, uncorr_o, wr_rej_o;
  logic [31:0] rdata_o;
  logic [8:0]  arr_addr_o;
  logic        arr_we_o, arr_erase_o;
  logic [37:0] arr_wdata_o, arr_rdata_i;
  logic [0:0]  arr_sector_o;

  logic [37:0] mem [512];
  logic        inj_en = 1'b0;
  logic [8:0]  inj_a = '0;
  logic [37:0] inj_m = '0;

  logic [31:0] sh_data [512];
  logic        sh_wr [512];
  int          wl [64];
  int          wcnt = 0;
  int          vectors = 0, fails = 0, cyc = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  flash_ecc_wrap u_flash_ecc_wrap (.*);

  assign arr_rdata_i = mem[arr_addr_o];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int w = 0; w < 512; w++) mem[w] <= '1;
    end else if (inj_en) begin
      mem[inj_a] <= mem[inj_a] ^ inj_m;
    end else if (arr_erase_o) begin
      for (int w = 0; w < 512; w++) if ((w / 256) == int'(arr_sector_o)) mem[w] <= '1;
    end else if (arr_we_o) begin
      mem[arr_addr_o] <= arr_wdata_o;
    end
  end

  function automatic int bpos(input int idx);
    int n = 0;
    int r = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = p;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [5:0] benc(input logic [31:0] d);
    logic [5:0] c = '0;
    for (int i = 0; i < 32; i++)
      for (int k = 0; k < 6; k++)
        if ((bpos(i) >> k) & 1) c[k] ^= d[i];
    return c;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string rq);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_wr(input logic [10:0] a, input logic [3:0] b, input logic [31:0] d,
                       input bit acc, input string rq);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; be_i = b; wdata_i = d;
    #1;
    chk(64'(arr_we_o), 64'(acc), rq);
    if (acc) chk(64'(arr_wdata_o), 64'({benc(d), d}), "R1");
    @(negedge clk_i);
    wr_i = 1'b0;
    chk(64'(wr_rej_o), 64'(!acc), rq);
    if (acc) begin
      sh_data[a[10:2]] = d;
      sh_wr[a[10:2]] = 1'b1;
    end
  endtask

  task automatic do_rd(input logic [10:0] a, input logic [31:0] ed, input bit ec,
                       input bit eu, input string rq);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk(64'(rvalid_o), 64'(1), "R6");
    chk(64'(rdata_o), 64'(ed), rq);
    chk(64'(corr_o), 64'(ec), rq);
    chk(64'(uncorr_o), 64'(eu), rq);
  endtask

  task automatic inject(input int w, input logic [37:0] m);
    @(negedge clk_i);
    inj_a = 9'(w); inj_m = m; inj_en = 1'b1;
    @(negedge clk_i);
    inj_en = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int w, kind, idx, k;
    logic [31:0] d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 512; i++) begin sh_data[i] = '1; sh_wr[i] = 1'b0; end

    // R11 reset state
    repeat (3) @(negedge clk_i);
    chk(64'(rvalid_o), 0, "R11");
    chk(64'(corr_o), 0, "R11");
    chk(64'(uncorr_o), 0, "R11");
    chk(64'(wr_rej_o), 0, "R11");
    chk(64'(arr_we_o), 0, "R11");
    rst_ni = 1'b1;

    // R5 erased reads
    do_rd(11'h000, 32'hFFFF_FFFF, 0, 0, "R5");
    do_rd(11'(300 * 4), 32'hFFFF_FFFF, 0, 0, "R5");

    // R1 all-ones data is not an erased word
    do_wr(11'(5 * 4), 4'hF, 32'hFFFF_FFFF, 1, "R1");
    wl[wcnt++] = 5;
    do_rd(11'(5 * 4), 32'hFFFF_FFFF, 0, 0, "R5");

    // random writes to words 0..399
    for (int n = 0; n < 40; n++) begin
      do w = int'($urandom % 400); while (sh_wr[w]);
      d = $urandom;
      do_wr(11'(w * 4), 4'hF, d, 1, "R1");
      wl[wcnt++] = w;
    end

    // R8 rewrites rejected, content kept
    for (int n = 0; n < 5; n++) begin
      w = wl[$urandom % wcnt];
      do_wr(11'(w * 4), 4'hF, ~sh_data[w], 0, "R8");
      do_rd(11'(w * 4), sh_data[w], 0, 0, "R8");
    end

    // R7 misaligned / partial writes to unwritten words 400..
    for (int n = 0; n < 6; n++) begin
      w = 400 + n;
      if (n < 3) do_wr(11'(w * 4 + n + 1), 4'hF, $urandom, 0, "R7");
      else       do_wr(11'(w * 4), 4'hF >> (n - 2), $urandom, 0, "R7");
      do_rd(11'(w * 4), 32'hFFFF_FFFF, 0, 0, "R7");
    end

    // fault-injected reads R2/R3/R4
    for (int n = 0; n < 60; n++) begin
      logic [37:0] m;
      w = wl[$urandom % wcnt];
      kind = int'($urandom % 4);
      case (kind)
        0: m = '0;
        1: begin idx = int'($urandom % 32); m = 38'(1) << idx; end
        2: begin k = int'($urandom % 6); m = 38'(1) << (32 + k); end
        default: begin idx = 3 + int'($urandom % 23); m = (38'(1) << 37) | (38'(1) << idx); end
      endcase
      if (kind != 0) inject(w, m);
      case (kind)
        0: do_rd(11'(w * 4), sh_data[w], 0, 0, "R2");
        1: do_rd(11'(w * 4), sh_data[w], 1, 0, "R2");
        2: do_rd(11'(w * 4), sh_data[w], 1, 0, "R3");
        default: do_rd(11'(w * 4), sh_data[w] ^ m[31:0], 0, 1, "R4");
      endcase
      if (kind != 0) begin
        // R6 flag lasts one cycle
        @(negedge clk_i);
        chk(64'(corr_o | uncorr_o | rvalid_o), 0, "R6");
        inject(w, m);
      end
    end

    // R4 directed: positions 32 and 7 -> syndrome 39
    w = wl[0];
    inject(w, (38'(1) << 37) | (38'(1) << 3));
    do_rd(11'(w * 4), sh_data[w] ^ 32'h8, 0, 1, "R4");
    inject(w, (38'(1) << 37) | (38'(1) << 3));

    // R10 write beats read
    @(negedge clk_i);
    wr_i = 1'b1; rd_i = 1'b1; addr_i = 11'(450 * 4); be_i = 4'hF; wdata_i = 32'hA5A5_0F0F;
    #1 chk(64'(arr_we_o), 1, "R10");
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    chk(64'(rvalid_o), 0, "R10");
    sh_data[450] = 32'hA5A5_0F0F; sh_wr[450] = 1'b1;

    // R10 erase beats write and read; R9 erase sector 0
    w = wl[1];
    @(negedge clk_i);
    erase_i = 1'b1; wr_i = 1'b1; rd_i = 1'b1; addr_i = 11'(w * 4); wdata_i = 32'h1234_5678;
    #1;
    chk(64'(arr_we_o), 0, "R10");
    chk(64'(arr_erase_o), 1, "R9");
    chk(64'(arr_sector_o), 64'(w / 256), "R9");
    @(negedge clk_i);
    erase_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
    chk(64'(rvalid_o), 0, "R10");
    chk(64'(wr_rej_o), 0, "R10");
    for (int i = 0; i < 256 * (1 + w / 256); i++) if (i / 256 == w / 256) begin
      sh_data[i] = '1; sh_wr[i] = 1'b0;
    end
    do_rd(11'(w * 4), 32'hFFFF_FFFF, 0, 0, "R9");
    do_wr(11'(w * 4), 4'hF, 32'h0BAD_CAFE, 1, "R9");
    do_rd(11'(w * 4), 32'h0BAD_CAFE, 0, 0, "R9");
    if (w / 256 == 0) begin
      do_wr(11'(450 * 4), 4'hF, 32'h0, 0, "R9");
      do_rd(11'(450 * 4), 32'hA5A5_0F0F, 0, 0, "R9");
    end else begin
      do_wr(11'(450 * 4), 4'hF, 32'h0, 1, "R9");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule